// File: doc/BRIEF.md
# Multi-Latency Issue Interlock

This block sits in the decode stage of an in-order, single-issue pipeline and decides, cycle by cycle, whether the instruction waiting there may enter its functional unit or must wait. The pipeline feeds five kinds of unit. The integer ALU and the memory path hand their results on through forwarding. The FP adder and the multiplier are pipelined, with latencies of 3 and 6 cycles. The divider is not pipelined: it has a 24-cycle result latency and a 25-cycle repeat interval.

The interlock keeps a countdown for every architectural register that has a result pending, plus one countdown for divider occupancy. A candidate waits if it reads a register whose countdown is still running (RAW). It waits if its destination already has a pending write that would land after its own write (WAW). It waits if it is a divide and the divider is still occupied (structural). Write-after-read and read-after-read need no check, because operands are read in decode. While a candidate waits, the surrounding logic holds it in place and no state in the interlock changes.

Top module: `issue_interlock`

## Requirements
- R1: `stall` is high exactly when `valid` is high and a hazard exists, and `issue` is high exactly when `valid` is high and no hazard exists. Both are low while `valid` is low. After reset, no register is pending and the divider is free.
- R2: Results from unit class 0 (integer ALU) and class 1 (memory) create no wait. An instruction that reads such a result can issue in the very next cycle.
- R3: An instruction that issues in cycle t with class 2 (FP add, L=3), class 3 (multiply, L=6) or class 4 (divide, L=24) and writes register x makes a later reader of x wait until cycle t+L+1. A reader presented in cycle t+1 stalls exactly L cycles.
- R4: A register's remaining count is L in the cycle after its writer issues and drops by one each cycle until it reaches zero. A candidate that writes a register stalls while that register's remaining count exceeds the candidate's own latency (WAW). A candidate with latency 0 therefore waits until the count reaches zero.
- R5: A stalled candidate loads no register countdown and does not occupy the divider. If the candidate is then withdrawn, a reader of its destination issues at once.
- R6: After a divide issues in cycle t, no other divide issues before cycle t+25. Instructions of other classes are not held up by divider occupancy.
- R7: Two reads of the same register, either within one instruction or across consecutive instructions, never cause a stall.
- R8: Register 0 is never pending. Reading it never stalls, and writing it creates no pending write and no WAW hazard.
- R9: A candidate with `writesRd` low creates no pending write and has no WAW check on `rd`.
- R10: Writing a register that an earlier instruction read (WAR) never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid | input | 1 | A candidate instruction is present in decode |
| unitClass | input | 3 | Unit class: 0 ALU, 1 memory, 2 FP add, 3 multiply, 4 divide |
| rs1 | input | 5 | First source register number |
| rs2 | input | 5 | Second source register number |
| rd | input | 5 | Destination register number |
| writesRd | input | 1 | Candidate writes `rd` |
| issue | output | 1 | Candidate enters its unit this cycle |
| stall | output | 1 | Candidate is held in decode this cycle |

## Verification
The bench sends a dependent reader straight after each producer class and counts the stall cycles. This separates the forwarded classes (no wait) from the 3-, 6- and 24-cycle classes, and it shows any off-by-one in the countdowns. WAW is tried with a long-latency write followed by a shorter one to the same register, and then a zero-latency one. That pair of cases tells the "greater than own latency" rule apart from a plain "pending" test. Divide spacing is measured with and without an independent instruction slipped in between. Register 0, `writesRd` low, repeated reads, WAR orderings and a withdrawn stalled divide each confirm that a non-hazard does not stall and leaves nothing pending.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  typedef enum logic [2:0] {
    UC_ALU  = 3'd0,
    UC_MEM  = 3'd1,
    UC_FADD = 3'd2,
    UC_MUL  = 3'd3,
    UC_DIV  = 3'd4
  } unitClass_e;

  localparam int STROBE_W = 8;

  // Strobes from control to the countdown datapath
  typedef struct packed {
    logic                loadDest;
    logic                loadDiv;
    logic [STROBE_W-1:0] destIdx;
    logic [STROBE_W-1:0] destLat;
  } ctlStrobe_t;

endpackage

// File: rtl/ilk_scoreboard.sv
module ilk_scoreboard
  import ilk_pkg::*;
#(
  parameter int REG_COUNT    = 32,
  parameter int ADDR_W       = 5,
  parameter int CNT_W        = 5,
  parameter int DIV_INTERVAL = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        ctl,
  input  logic [ADDR_W-1:0] rs1,
  input  logic [ADDR_W-1:0] rs2,
  input  logic [ADDR_W-1:0] rd,
  output logic              src1Pending,
  output logic              src2Pending,
  output logic [CNT_W-1:0]  destRemain,
  output logic              divBusy
);

  localparam logic [CNT_W-1:0] DIV_RELOAD = CNT_W'(DIV_INTERVAL - 1);

  logic [CNT_W-1:0]  regCnt [REG_COUNT];
  logic [CNT_W-1:0]  divCnt;
  logic [ADDR_W-1:0] loadIdx;
  logic [CNT_W-1:0]  loadLat;

  assign loadIdx = ctl.destIdx[ADDR_W-1:0];
  assign loadLat = ctl.destLat[CNT_W-1:0];

  generate
    for (genvar g = 0; g < REG_COUNT; g++) begin : gRegCnt
      if (g == 0) begin : gZero
        always_ff @(posedge clk) begin
          regCnt[g] <= '0;
        end
      end else begin : gLive
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            regCnt[g] <= '0;
          end else if (ctl.loadDest && (loadIdx == ADDR_W'(g))) begin
            regCnt[g] <= loadLat;
          end else if (regCnt[g] != '0) begin
            regCnt[g] <= regCnt[g] - 1'b1;
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      divCnt <= '0;
    end else if (ctl.loadDiv) begin
      divCnt <= DIV_RELOAD;
    end else if (divCnt != '0) begin
      divCnt <= divCnt - 1'b1;
    end
  end

  assign src1Pending = (regCnt[rs1] != '0);
  assign src2Pending = (regCnt[rs2] != '0);
  assign destRemain  = regCnt[rd];
  assign divBusy     = (divCnt != '0);

endmodule

// File: rtl/ilk_control.sv
module ilk_control
  import ilk_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int CNT_W    = 5,
  parameter int LAT_FADD = 3,
  parameter int LAT_MUL  = 6,
  parameter int LAT_DIV  = 24
) (
  input  logic              valid,
  input  logic [2:0]        unitClass,
  input  logic [ADDR_W-1:0] rd,
  input  logic              writesRd,
  input  logic              src1Pending,
  input  logic              src2Pending,
  input  logic [CNT_W-1:0]  destRemain,
  input  logic              divBusy,
  output logic              issue,
  output logic              stall,
  output ctlStrobe_t        ctl
);

  logic [CNT_W-1:0] candLat;
  logic             isDiv;
  logic             destLive;
  logic             rawHaz;
  logic             wawHaz;
  logic             structHaz;
  logic             hazard;

  always_comb begin
    candLat = '0;
    isDiv   = 1'b0;
    case (unitClass_e'(unitClass))
      UC_FADD: candLat = CNT_W'(LAT_FADD);
      UC_MUL:  candLat = CNT_W'(LAT_MUL);
      UC_DIV: begin
        candLat = CNT_W'(LAT_DIV);
        isDiv   = 1'b1;
      end
      default: candLat = '0;
    endcase
  end

  always_comb begin
    destLive  = writesRd && (rd != '0);
    rawHaz    = src1Pending || src2Pending;
    wawHaz    = destLive && (destRemain > candLat);
    structHaz = isDiv && divBusy;
    hazard    = rawHaz || wawHaz || structHaz;
    issue     = valid && !hazard;
    stall     = valid && hazard;
  end

  always_comb begin
    ctl          = '0;
    ctl.loadDest = issue && destLive;
    ctl.loadDiv  = issue && isDiv;
    ctl.destIdx  = STROBE_W'(rd);
    ctl.destLat  = STROBE_W'(candLat);
  end

endmodule

// File: rtl/issue_interlock.sv
module issue_interlock
  import ilk_pkg::*;
#(
  parameter int REG_COUNT    = 32,
  parameter int LAT_FADD     = 3,
  parameter int LAT_MUL      = 6,
  parameter int LAT_DIV      = 24,
  parameter int DIV_INTERVAL = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       valid,
  input  logic [2:0] unitClass,
  input  logic [4:0] rs1,
  input  logic [4:0] rs2,
  input  logic [4:0] rd,
  input  logic       writesRd,
  output logic       issue,
  output logic       stall
);

  localparam int ADDR_W = 5;
  localparam int MAX_V  = (LAT_DIV > DIV_INTERVAL) ? LAT_DIV : DIV_INTERVAL;
  localparam int CNT_W  = $clog2(MAX_V + 1);

  ctlStrobe_t       ctl;
  logic             src1Pending;
  logic             src2Pending;
  logic [CNT_W-1:0] destRemain;
  logic             divBusy;

  ilk_scoreboard #(
    .REG_COUNT    (REG_COUNT),
    .ADDR_W       (ADDR_W),
    .CNT_W        (CNT_W),
    .DIV_INTERVAL (DIV_INTERVAL)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl         (ctl),
    .rs1         (rs1),
    .rs2         (rs2),
    .rd          (rd),
    .src1Pending (src1Pending),
    .src2Pending (src2Pending),
    .destRemain  (destRemain),
    .divBusy     (divBusy)
  );

  ilk_control #(
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .LAT_FADD (LAT_FADD),
    .LAT_MUL  (LAT_MUL),
    .LAT_DIV  (LAT_DIV)
  ) u_ctl (
    .valid       (valid),
    .unitClass   (unitClass),
    .rd          (rd),
    .writesRd    (writesRd),
    .src1Pending (src1Pending),
    .src2Pending (src2Pending),
    .destRemain  (destRemain),
    .divBusy     (divBusy),
    .issue       (issue),
    .stall       (stall),
    .ctl         (ctl)
  );

endmodule

// File: rtl/ilk_checker.sv
module ilk_checker #(
  parameter int DIV_INTERVAL = 25
) (
  input logic       clk,
  input logic       rst_n,
  input logic       valid,
  input logic [2:0] unitClass,
  input logic [4:0] rs1,
  input logic [4:0] rs2,
  input logic [4:0] rd,
  input logic       writesRd,
  input logic       issue,
  input logic       stall
);

  localparam int GAP_W = $clog2(DIV_INTERVAL + 1) + 1;

  logic [GAP_W-1:0] sinceDiv;
  logic             seenDiv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sinceDiv <= '0;
      seenDiv  <= 1'b0;
    end else if (issue && unitClass == 3'd4) begin
      sinceDiv <= GAP_W'(1);
      seenDiv  <= 1'b1;
    end else if (sinceDiv < GAP_W'(DIV_INTERVAL)) begin
      sinceDiv <= sinceDiv + 1'b1;
    end
  end

  AST_ISSUE_STALL_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (issue || stall) == valid && !(issue && stall)); // R1

  AST_DIV_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && unitClass == 3'd4 && seenDiv) |-> sinceDiv >= GAP_W'(DIV_INTERVAL)); // R6

  AST_FADD_RAW_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && unitClass == 3'd2 && writesRd && rd != 5'd0)
      |=> !(issue && (rs1 == $past(rd) || rs2 == $past(rd)))); // R3

  AST_ZERO_SOURCES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && rs1 == 5'd0 && rs2 == 5'd0 && unitClass != 3'd4 && (!writesRd || rd == 5'd0))
      |-> issue); // R8

endmodule

bind issue_interlock ilk_checker #(.DIV_INTERVAL(DIV_INTERVAL)) u_ilk_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .valid     (valid),
  .unitClass (unitClass),
  .rs1       (rs1),
  .rs2       (rs2),
  .rd        (rd),
  .writesRd  (writesRd),
  .issue     (issue),
  .stall     (stall)
);

// File: tb/issue_interlock_bench.sv
module issue_interlock_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [2:0] unitClass = '0;
  logic [4:0] rs1 = '0;
  logic [4:0] rs2 = '0;
  logic [4:0] rd = '0;
  logic       writesRd = 1'b0;
  logic       issue;
  logic       stall;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    bit    expIssue;
    string req;
  } item_t;
  item_t q[$];

  localparam bit [2:0] C_ALU = 3'd0, C_MEM = 3'd1, C_FADD = 3'd2, C_MUL = 3'd3, C_DIV = 3'd4;

  always #4 clk = ~clk;

  issue_interlock u_issue_interlock (
    .clk(clk), .rst_n(rst_n), .valid(valid), .unitClass(unitClass),
    .rs1(rs1), .rs2(rs2), .rd(rd), .writesRd(writesRd),
    .issue(issue), .stall(stall)
  );

  // Monitor: compares each cycle's outputs mid-cycle against the queued expectation
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      bit expStall;
      it = q.pop_front();
      expStall = valid && !it.expIssue;
      checks++;
      if (issue !== it.expIssue || stall !== expStall) begin
        fails++;
        $display("FAIL %s: issue=%0b stall=%0b expected issue=%0b stall=%0b",
                 it.req, issue, stall, it.expIssue, expStall);
      end
    end
  end

  task automatic drive(bit v, bit [2:0] c, int a, int b, int d, bit w, bit e, string req);
    @(posedge clk);
    #1;
    valid = v; unitClass = c; rs1 = 5'(a); rs2 = 5'(b); rd = 5'(d); writesRd = w;
    q.push_back('{e, req});
  endtask

  // Present a candidate: n stall cycles, then issue
  task automatic hold(bit [2:0] c, int a, int b, int d, bit w, int n, string req);
    for (int i = 0; i < n; i++) drive(1, c, a, b, d, w, 0, req);
    drive(1, c, a, b, d, w, 1, req);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, C_ALU, 0, 0, 0, 0, 0, "R1");
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (issue !== 1'b0 || stall !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: issue=%0b stall=%0b expected 0 0", issue, stall);
    end

    // R1: idle cycles, then reader of every-type register right after reset issues
    idle(2);
    hold(C_ALU, 9, 20, 21, 1, 0, "R1 nothing pending after reset");

    // R2: ALU and memory results forward
    hold(C_ALU, 1, 2, 5, 1, 0, "R2 alu producer");
    hold(C_ALU, 5, 0, 6, 1, 0, "R2 alu reader next cycle");
    hold(C_MEM, 0, 0, 19, 1, 0, "R2 mem producer");
    hold(C_FADD, 0, 19, 22, 1, 0, "R2 mem reader next cycle");
    idle(8);

    // R3: FP add RAW, 3 stalls
    hold(C_FADD, 1, 2, 6, 1, 0, "R3 fadd producer");
    hold(C_ALU, 6, 0, 7, 1, 3, "R3 fadd reader");
    // R3: multiply RAW on rs2, 6 stalls
    hold(C_MUL, 1, 2, 8, 1, 0, "R3 mul producer");
    hold(C_ALU, 0, 8, 7, 1, 6, "R3 mul reader");
    // R3: divide RAW, 24 stalls
    hold(C_DIV, 1, 2, 23, 1, 0, "R3 div producer");
    hold(C_ALU, 23, 0, 0, 0, 24, "R3 div reader");
    idle(30);

    // R4: multiply then fadd to same rd: stall while count 6,5,4 exceeds 3
    hold(C_MUL, 1, 2, 9, 1, 0, "R4 mul writer");
    hold(C_FADD, 0, 0, 9, 1, 3, "R4 fadd waw");
    // R4: alu to same rd waits for the fadd's count 3,2,1 to drain
    hold(C_ALU, 0, 0, 9, 1, 3, "R4 alu waw");
    // R4: shorter latency pending under a longer writer does not stall
    hold(C_FADD, 1, 2, 24, 1, 0, "R4 fadd writer");
    hold(C_MUL, 0, 0, 24, 1, 0, "R4 longer writer no stall");
    idle(10);

    // R6: divide spacing with an independent op in between
    hold(C_DIV, 1, 2, 10, 1, 0, "R6 first div");
    hold(C_FADD, 1, 2, 12, 1, 0, "R6 non-div during busy");
    hold(C_DIV, 1, 2, 11, 1, 23, "R6 second div");
    idle(30);
    // R6: back-to-back divides, 24 stalls
    hold(C_DIV, 1, 2, 25, 1, 0, "R6 div a");
    hold(C_DIV, 3, 4, 26, 1, 24, "R6 div b");
    idle(30);

    // R5: a stalled divide that is withdrawn leaves nothing pending
    hold(C_DIV, 1, 2, 17, 1, 0, "R5 div occupying");
    drive(1, C_DIV, 0, 0, 18, 1, 0, "R5 stalled div");
    hold(C_ALU, 18, 18, 0, 0, 0, "R5 reader of withdrawn rd");
    hold(C_ALU, 0, 0, 18, 1, 0, "R5 writer of withdrawn rd");
    idle(30);

    // R7: same register read twice, and by consecutive instructions
    hold(C_ALU, 3, 3, 27, 1, 0, "R7 rs1 equals rs2");
    hold(C_MUL, 3, 3, 28, 1, 0, "R7 second reader");
    hold(C_FADD, 3, 4, 29, 1, 0, "R7 third reader");

    // R8: register 0
    hold(C_FADD, 1, 2, 0, 1, 0, "R8 fadd to r0");
    hold(C_ALU, 0, 0, 30, 1, 0, "R8 read r0");
    hold(C_ALU, 0, 0, 0, 1, 0, "R8 write r0 no waw");

    // R9: writesRd low
    hold(C_MUL, 1, 2, 13, 0, 0, "R9 mul no write");
    hold(C_ALU, 13, 13, 13, 1, 0, "R9 read and write r13");
    hold(C_FADD, 1, 2, 14, 1, 0, "R9 fadd writer");
    hold(C_ALU, 0, 0, 14, 0, 0, "R9 no waw when not writing");
    idle(8);

    // R10: WAR
    hold(C_ALU, 15, 16, 31, 1, 0, "R10 reader");
    hold(C_MUL, 0, 0, 15, 1, 0, "R10 write after read");
    hold(C_DIV, 16, 0, 16, 1, 0, "R10 div writes own source");
    idle(3);

    summary();
    $finish;
  end

endmodule